// File: doc/BRIEF.md
# In-Place Exchange Sorter

This block sorts a set of unsigned words held in a small internal single-port RAM. The RAM has `2**ADDR_W` entries, and all of them take part in the sort. A host uses the block in two phases. While `start` is low, the host writes words into the RAM and reads them back through a simple strobe-and-address interface. When the host raises `start`, the block rearranges the RAM contents into ascending order by address and then raises `done`.

The design has a datapath and a controller. The datapath holds the RAM with its registered read port, two operand registers (`A` and `B`), two index counters (outer `i` and inner `j`), an address multiplexer, a write-data multiplexer and a greater-than comparator. The controller is an enumerated state machine that walks the outer and inner loops:

- **ST_IDLE**: host access. It goes to ST_RD_A when `start` is high.
- **ST_RD_A**: addresses `M[i]` and loads `j = i+1`. Goes to ST_CAP_A.
- **ST_CAP_A**: captures `A`. Goes to ST_RD_B.
- **ST_RD_B**: addresses `M[j]`. Goes to ST_CAP_B.
- **ST_CAP_B**: captures `B`. Goes to ST_CMP.
- **ST_CMP**: goes to ST_WR_I when `A > B`, otherwise to ST_NEXT.
- **ST_WR_I**: writes `B` into `M[i]`. Goes to ST_WR_J.
- **ST_WR_J**: writes `A` into `M[j]`. Goes to ST_RELOAD.
- **ST_RELOAD**: addresses `M[i]`. Goes to ST_CAP_R.
- **ST_CAP_R**: recaptures `A`. Goes to ST_NEXT.
- **ST_NEXT**: goes to ST_RD_B and increments `j` when `j` is not yet last. Otherwise it goes to ST_RD_A and increments `i` when `i` is not yet the second-to-last index. Otherwise it goes to ST_DONE.
- **ST_DONE**: goes back to ST_IDLE when `start` falls.

Every RAM read spends one state presenting the address and the next state capturing the data.

Top module: `exsort_top`

## Requirements
- R1: While the controller is idle and `start` is low, a cycle with `wr_en` high stores `wr_data` at RAM location `addr` on that clock edge.
- R2: While idle with `start` low, a cycle with `rd_en` high places the word at `addr` on `rd_data` after the next clock edge. While `rd_en` is low, `rd_data` keeps its value.
- R3: Once `start` is high, the block sorts the whole RAM in place, leaving the smallest word at address 0 and non-decreasing values toward the highest address. With eight words 3,2,4,1,7,5,8,6 at addresses 0..7, the result is 1..8.
- R4: `done` rises when sorting completes and stays high while `start` stays high. In the first cycle in which `start` is low, the controller returns to idle and `done` is low after that clock edge.
- R5: Two words of equal value are never exchanged, so a RAM whose words are all equal is left unchanged and takes no exchange cycles.
- R6: Timing is fixed by the data. Counting the first clock edge that samples `start` high as cycle 1, `done` is high after edge number 1 + 2(K-1) + 4·C + 4·S. Here K is the RAM depth, C = K(K-1)/2 is the number of comparisons, and S is the number of exchanges that the nested i/j exchange algorithm performs on the loaded data.
- R7: An active-low `rst_n` returns the controller to idle and clears `done`, even in the middle of a sort. It leaves the RAM contents intact.
- R8: A `wr_en` pulse while `start` is high does not alter the RAM. A write attempted in the done phase is absent when the RAM is read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of controller and registers |
| wr_data | input | DATA_W | Word written by the host |
| addr | input | ADDR_W | Host RAM address |
| wr_en | input | 1 | Host write strobe |
| start | input | 1 | Low: host access mode; high: sort and hold result |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | DATA_W | Registered RAM read data |
| done | output | 1 | Sort finished; held until `start` falls |

## Verification
The hardest condition to reach is a tie in the comparator. A tie must produce no exchange, but its only visible trace at the ports is a shorter sort. The bench therefore loads patterns with duplicates, including one with all words equal, and compares the cycle count from `start` to `done` against an exact figure. That figure comes from the number of exchanges, computed independently in the bench. An unwanted swap on equality shows up as four extra cycles. A reset in the middle of a sort and a write strobe during the done phase are applied at chosen moments and then checked by reading the RAM back.

// File: rtl/exsort_pkg.sv
package exsort_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_A,
        ST_CAP_A,
        ST_RD_B,
        ST_CAP_B,
        ST_CMP,
        ST_WR_I,
        ST_WR_J,
        ST_RELOAD,
        ST_CAP_R,
        ST_NEXT,
        ST_DONE
    } sort_state_e;

    // Control bundle from the controller to the datapath
    typedef struct packed {
        logic host_sel;  // host owns RAM address and write data
        logic ram_we;    // RAM write strobe
        logic ram_re;    // RAM read strobe
        logic sel_j;     // sort address: 1 = j, 0 = i
        logic wr_b;      // sort write data: 1 = B, 0 = A
        logic ld_a;
        logic ld_b;
        logic clr_i;
        logic inc_i;
        logic ld_j;
        logic inc_j;
    } sort_ctrl_t;

endpackage

// File: rtl/exsort_ram.sv
module exsort_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ram_addr,
    input  logic [DATA_W-1:0] ram_wdata,
    input  logic              ram_we,
    input  logic              ram_re,
    output logic [DATA_W-1:0] ram_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage has no reset: contents survive rst_n
    always_ff @(posedge clk) begin
        if (ram_we) begin
            mem[ram_addr] <= ram_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ram_rdata <= '0;
        end else if (ram_re) begin
            ram_rdata <= mem[ram_addr];
        end
    end
endmodule

// File: rtl/exsort_datapath.sv
module exsort_datapath
    import exsort_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sort_ctrl_t        ctrl,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [DATA_W-1:0] rdata,
    output logic              a_gt_b,
    output logic              i_last,
    output logic              j_last,
    output logic [ADDR_W-1:0] i_idx,
    output logic [ADDR_W-1:0] j_idx
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] I_END = ADDR_W'(DEPTH - 2);
    localparam logic [ADDR_W-1:0] J_END = ADDR_W'(DEPTH - 1);

    logic [DATA_W-1:0] reg_a;
    logic [DATA_W-1:0] reg_b;
    logic [ADDR_W-1:0] mux_addr;
    logic [DATA_W-1:0] mux_wdata;

    always_comb begin
        if (ctrl.host_sel) begin
            mux_addr  = host_addr;
            mux_wdata = host_wdata;
        end else begin
            mux_addr  = ctrl.sel_j ? j_idx : i_idx;
            mux_wdata = ctrl.wr_b ? reg_b : reg_a;
        end
    end

    exsort_ram #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .ram_addr  (mux_addr),
        .ram_wdata (mux_wdata),
        .ram_we    (ctrl.ram_we),
        .ram_re    (ctrl.ram_re),
        .ram_rdata (rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_a <= '0;
            reg_b <= '0;
        end else begin
            if (ctrl.ld_a) reg_a <= rdata;
            if (ctrl.ld_b) reg_b <= rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_idx <= '0;
        end else if (ctrl.clr_i) begin
            i_idx <= '0;
        end else if (ctrl.inc_i) begin
            i_idx <= i_idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            j_idx <= '0;
        end else if (ctrl.ld_j) begin
            j_idx <= i_idx + 1'b1;
        end else if (ctrl.inc_j) begin
            j_idx <= j_idx + 1'b1;
        end
    end

    assign a_gt_b = reg_a > reg_b;
    assign i_last = i_idx == I_END;
    assign j_last = j_idx == J_END;
endmodule

// File: rtl/exsort_ctrl.sv
module exsort_ctrl
    import exsort_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic        a_gt_b,
    input  logic        i_last,
    input  logic        j_last,
    output sort_state_e state,
    output sort_ctrl_t  ctrl,
    output logic        done
);
    sort_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_RD_A;
            ST_RD_A:   state_nx = ST_CAP_A;
            ST_CAP_A:  state_nx = ST_RD_B;
            ST_RD_B:   state_nx = ST_CAP_B;
            ST_CAP_B:  state_nx = ST_CMP;
            ST_CMP:    state_nx = a_gt_b ? ST_WR_I : ST_NEXT;
            ST_WR_I:   state_nx = ST_WR_J;
            ST_WR_J:   state_nx = ST_RELOAD;
            ST_RELOAD: state_nx = ST_CAP_R;
            ST_CAP_R:  state_nx = ST_NEXT;
            ST_NEXT: begin
                if (!j_last)      state_nx = ST_RD_B;
                else if (!i_last) state_nx = ST_RD_A;
                else              state_nx = ST_DONE;
            end
            ST_DONE:   if (!start) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        ctrl = '0;
        done = 1'b0;
        unique case (state)
            ST_IDLE: begin
                ctrl.host_sel = 1'b1;
                ctrl.ram_we   = wr_en & ~start;
                ctrl.ram_re   = rd_en & ~start;
                ctrl.clr_i    = start;
            end
            ST_RD_A: begin
                ctrl.ram_re = 1'b1;
                ctrl.ld_j   = 1'b1;
            end
            ST_CAP_A:  ctrl.ld_a = 1'b1;
            ST_RD_B: begin
                ctrl.ram_re = 1'b1;
                ctrl.sel_j  = 1'b1;
            end
            ST_CAP_B:  ctrl.ld_b = 1'b1;
            ST_CMP:    ;
            ST_WR_I: begin
                ctrl.ram_we = 1'b1;
                ctrl.wr_b   = 1'b1;
            end
            ST_WR_J: begin
                ctrl.ram_we = 1'b1;
                ctrl.sel_j  = 1'b1;
            end
            ST_RELOAD: ctrl.ram_re = 1'b1;
            ST_CAP_R:  ctrl.ld_a = 1'b1;
            ST_NEXT: begin
                ctrl.inc_j = ~j_last;
                ctrl.inc_i = j_last & ~i_last;
            end
            ST_DONE:   done = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/exsort_top.sv
module exsort_top
    import exsort_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              start,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);
    sort_state_e       state;
    sort_ctrl_t        ctrl;
    logic              a_gt_b;
    logic              i_last;
    logic              j_last;
    logic [ADDR_W-1:0] i_idx;
    logic [ADDR_W-1:0] j_idx;

    exsort_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .a_gt_b (a_gt_b),
        .i_last (i_last),
        .j_last (j_last),
        .state  (state),
        .ctrl   (ctrl),
        .done   (done)
    );

    exsort_datapath #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl       (ctrl),
        .host_wdata (wr_data),
        .host_addr  (addr),
        .rdata      (rd_data),
        .a_gt_b     (a_gt_b),
        .i_last     (i_last),
        .j_last     (j_last),
        .i_idx      (i_idx),
        .j_idx      (j_idx)
    );
endmodule

// File: rtl/exsort_chk.sv
module exsort_chk
    import exsort_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input sort_state_e       state,
    input logic              ram_we,
    input logic              a_gt_b,
    input logic [ADDR_W-1:0] i_idx,
    input logic [ADDR_W-1:0] j_idx
);
    // R4: done persists while start is held
    a_r4_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> done);

    // R4: start falling releases done and returns to idle
    a_r4_done_release: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (!done && state == ST_IDLE));

    // R5: a tie or a smaller A never causes a RAM write
    a_r5_no_write_on_tie: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMP && !a_gt_b) |=> !ram_we);

    // R3: an exchange writes both locations back to back
    a_r3_swap_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_I) |=> (state == ST_WR_J && ram_we));

    // R3: inner index is always beyond the outer one when B is taken
    a_r3_j_beyond_i: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAP_B) |-> (j_idx > i_idx));

    // R1: without start the controller stays in host mode
    a_r1_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> state == ST_IDLE);

    // R7: reset forces done low
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r7_reset_done_low: assert (!done);
        end
    end
endmodule

bind exsort_top exsort_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .done   (done),
    .state  (state),
    .ram_we (ctrl.ram_we),
    .a_gt_b (a_gt_b),
    .i_idx  (i_idx),
    .j_idx  (j_idx)
);

// File: tb/exsort_top_tb.sv
module exsort_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int AW = 3;
    localparam int K  = 1 << AW;
    localparam int CMPS = K * (K - 1) / 2;
    localparam int NVEC = 6;

    // Word w of a vector sits in bits [w*8 +: 8]
    localparam logic [K*DW-1:0] VECS [NVEC] = '{
        {8'd6, 8'd8, 8'd5, 8'd7, 8'd1, 8'd4, 8'd2, 8'd3},
        {8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8},
        {8'd8, 8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1},
        {8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h5A},
        {8'h00, 8'hFF, 8'h10, 8'h10, 8'hFF, 8'h00, 8'h80, 8'h10},
        {8'h33, 8'h11, 8'h33, 8'h22, 8'h11, 8'h22, 8'h44, 8'h00}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic          start = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exsort_top #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .addr(addr),
        .wr_en(wr_en), .start(start), .rd_en(rd_en),
        .rd_data(rd_data), .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic host_write(input int a, input int d);
        @(negedge clk);
        addr = AW'(a); wr_data = DW'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic host_read(input int a, output int d);
        @(negedge clk);
        addr = AW'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = int'(rd_data);
    endtask

    task automatic load_vec(input logic [K*DW-1:0] v);
        for (int w = 0; w < K; w++) host_write(w, int'(v[w*DW +: DW]));
    endtask

    // Reference: nested exchange algorithm, counting exchanges
    task automatic model(input logic [K*DW-1:0] v, output logic [K*DW-1:0] r,
                         output int swaps);
        int m [K];
        int t;
        swaps = 0;
        for (int w = 0; w < K; w++) m[w] = int'(v[w*DW +: DW]);
        for (int i = 0; i <= K - 2; i++) begin
            for (int j = i + 1; j <= K - 1; j++) begin
                if (m[i] > m[j]) begin
                    t = m[i]; m[i] = m[j]; m[j] = t; swaps++;
                end
            end
        end
        r = '0;
        for (int w = 0; w < K; w++) r[w*DW +: DW] = DW'(m[w]);
    endtask

    task automatic run_sort(output int cyc);
        @(negedge clk);
        start = 1'b1;
        cyc = 0;
        do begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end while (!done && cyc < 4000);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int rv, cyc, swaps;
        logic [K*DW-1:0] sorted;

        repeat (3) @(negedge clk);
        check("R7 done low in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 done low after reset", int'(done), 0);

        for (int v = 0; v < NVEC; v++) begin
            load_vec(VECS[v]);
            for (int w = 0; w < K; w++) begin
                host_read(w, rv);
                check("R1 R2 readback", rv, int'(VECS[v][w*DW +: DW]));
            end
            model(VECS[v], sorted, swaps);
            run_sort(cyc);
            check("R6 cycles to done", cyc, 1 + 2*(K-1) + 4*CMPS + 4*swaps);
            if (v == 3) check("R5 all-equal takes no exchange", cyc, 1 + 2*(K-1) + 4*CMPS);
            // R8: write while start high in done phase
            @(negedge clk);
            addr = '0; wr_data = 8'hAA; wr_en = 1'b1;
            @(negedge clk);
            wr_en = 1'b0;
            check("R4 done held", int'(done), 1);
            repeat (2) @(negedge clk);
            check("R4 done still held", int'(done), 1);
            start = 1'b0;
            @(negedge clk);
            check("R4 done drops after start low", int'(done), 0);
            for (int w = 0; w < K; w++) begin
                host_read(w, rv);
                check(w == 0 ? "R8 R3 sorted word" : "R3 sorted word",
                      rv, int'(sorted[w*DW +: DW]));
            end
        end

        // R2: rd_data holds while rd_en is low
        host_read(K - 1, rv);
        @(negedge clk);
        addr = '0;
        @(negedge clk);
        check("R2 rd_data holds", int'(rd_data), rv);

        // R7: reset mid-sort, then RAM retained and host access works
        load_vec(VECS[2]);
        @(negedge clk);
        start = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 done low during mid-sort reset", int'(done), 0);
        start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        for (int w = 0; w < K; w++) begin
            host_read(w, rv);
            check("R7 RAM kept across reset", rv, int'(VECS[2][w*DW +: DW]));
        end
        host_write(4, 8'h77);
        host_read(4, rv);
        check("R7 R1 host access after reset", rv, 8'h77);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule